// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block is a small memory-mapped register bank that sits between a host register bus and a storage-interface PHY. Seven 32-bit control words hold the PHY's configuration. A single read-only word reports two status flags that come back from the PHY. The bus is single-cycle. A write strobe stores data in the same clock. A read strobe loads the read-data register at the next clock edge.

Each control word protects itself bit by bit. The upper sixteen bits of every written word act as enables for the lower sixteen. Software can therefore change one field without reading the word back first, and without disturbing fields that another agent owns. Named fields in two of the control words are decoded and driven straight out as PHY control ports: analog power-up, DLL enable, drive-strength code, DLL frequency band, output tap-delay enable and tap-delay select. The two status inputs pass through a configurable synchroniser before they can be read.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After reset every stored control bit is 0. Every PHY control output is therefore 0, with the analog section powered down and the DLL off, and the read-data register is 0.
- R2: On a write to a control word, stored bit x (0 to 15) takes write-data bit x exactly when write-data bit x+16 is 1. Every other stored bit keeps its value.
- R3: A write whose upper sixteen bits are all 0 leaves the addressed control word unchanged.
- R4: A read of a control word returns the stored sixteen bits in bits 15:0 and zero in bits 31:16. The read data appears in the clock after the read strobe and holds until the next read.
- R5: The control words are selected by byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 (word index 0 to 6). A write to one word never changes another word.
- R6: The word at 0x18 drives the PHY as follows: bit 0 is the analog power-up (1 = on), bit 1 is the DLL enable, and bits 6:4 are the 3-bit drive-strength code.
- R7: The word at 0x00 drives the PHY as follows: bits 13:12 are the 2-bit DLL frequency band, bit 11 is the output tap-delay enable, and bits 10:7 are the 4-bit tap-delay select.
- R8: A read of offset 0x20 returns the synchronised calibration-done input in bit 6 and the synchronised DLL-locked input in bit 5, with all other bits 0. An input change becomes visible in that word after SYNC_STAGES clock edges.
- R9: A write to 0x20, to any offset that is not 4-byte aligned, or to any offset with no register changes nothing. A read of an offset with no register, or of one that is not aligned, returns 0.
- R10: PHY control outputs change only in the clock after a write that reaches their word. They are stable at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and PHY control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write word: enables in 31:16, data in 15:0 |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration-done flag from the PHY |
| dll_lock_i | input | 1 | DLL-locked flag from the PHY |
| ana_pwr_on | output | 1 | Analog section power-up |
| dll_enable | output | 1 | DLL enable |
| drv_strength | output | 3 | Output drive-strength code |
| dll_band | output | 2 | DLL frequency band select |
| otap_enable | output | 1 | Output tap-delay enable |
| otap_select | output | 4 | Output tap-delay select |

## Verification
The bench builds the block with ADDR_W = 8, NUM_CTRL = 7, status at 0x20 and SYNC_STAGES = 2. With these values the first unmapped aligned word (0x1C) lies right beside the last control word, the status word lies beyond a gap, and offsets up to 0xFC test how the word index decodes out of range. The two-stage synchroniser makes the delay of the status flags a real, countable latency. A behavioural reference model follows every control word, the status pipeline and the read register, and is compared with the ports on every clock while mixed random enable masks exercise partial and empty updates.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;

   localparam int WORD_W = 32;
   localparam int HALF_W = WORD_W / 2;

   // power / DLL / drive word
   localparam int PWR_REG    = 6;
   localparam int PWR_BIT    = 0;
   localparam int DLLEN_BIT  = 1;
   localparam int DRV_LSB    = 4;
   localparam int DRV_W      = 3;

   // frequency band / tap delay word
   localparam int TAP_REG    = 0;
   localparam int BAND_LSB   = 12;
   localparam int BAND_W     = 2;
   localparam int TAPEN_BIT  = 11;
   localparam int TAPSEL_LSB = 7;
   localparam int TAPSEL_W   = 4;

   // status word
   localparam int CAL_BIT    = 6;
   localparam int LOCK_BIT   = 5;
   localparam int STAT_W     = 2;

   localparam logic [WORD_W-1:0] STATUS_MASK =
      (WORD_W'(1) << CAL_BIT) | (WORD_W'(1) << LOCK_BIT);

endpackage

// File: rtl/phy_hiword_reg.sv
module phy_hiword_reg #(
   parameter int HALF_W = 16,
   parameter logic [HALF_W-1:0] RESET_VAL = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2*HALF_W-1:0]   wr_word,
   output logic [HALF_W-1:0]     q
);

   localparam int ENA_LSB = HALF_W;

   if (HALF_W < 1 || HALF_W > 32) begin : g_bad_width
      $error("phy_hiword_reg: HALF_W must be 1..32");
   end

   logic [HALF_W-1:0] ena;
   assign ena = wr_word[ENA_LSB +: HALF_W];

   for (genvar b = 0; b < HALF_W; b++) begin : g_bit
      logic bit_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_r <= RESET_VAL[b];
         else if (wr_en && ena[b])
            bit_r <= wr_word[b];
      end
      assign q[b] = bit_r;
   end

   // R3
   zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ena == '0) |=> $stable(q));

   // R2
   enabled_bits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(ena)) == ($past(wr_word[HALF_W-1:0]) & $past(ena))));

   // R2
   disabled_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (((q ^ $past(q)) & ~$past(ena)) == '0));

endmodule

// File: rtl/phy_status_sync.sv
module phy_status_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("phy_status_sync: STAGES must be 0..4");
   end
   if (WIDTH < 1) begin : g_bad_w
      $error("phy_status_sync: WIDTH must be positive");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
         end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
         end
      end
      assign q = pipe[STAGES-1];

      // R8
      sync_first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (pipe[0] == $past(d)));
   end

endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
   import phy_regbank_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int NUM_CTRL      = 7,
   parameter int STATUS_OFFSET = 32'h20,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   input  logic                reg_wr,
   input  logic                reg_rd,
   output logic [WORD_W-1:0]   reg_rdata,
   input  logic                cal_done_i,
   input  logic                dll_lock_i,
   output logic                ana_pwr_on,
   output logic                dll_enable,
   output logic [DRV_W-1:0]    drv_strength,
   output logic [BAND_W-1:0]   dll_band,
   output logic                otap_enable,
   output logic [TAPSEL_W-1:0] otap_select
);

   localparam int IDX_W      = ADDR_W - 2;
   localparam int STATUS_IDX = STATUS_OFFSET / 4;
   localparam logic [IDX_W-1:0] NUM_CTRL_V   = IDX_W'(NUM_CTRL);
   localparam logic [IDX_W-1:0] STATUS_IDX_V = IDX_W'(STATUS_IDX);
   localparam logic [IDX_W-1:0] PWR_IDX_V    = IDX_W'(PWR_REG);

   // elaboration-time parameter checks
   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr
      $error("phy_ctl_regbank: ADDR_W must be 3..16");
   end
   if (NUM_CTRL <= PWR_REG || NUM_CTRL <= TAP_REG) begin : g_bad_count
      $error("phy_ctl_regbank: NUM_CTRL too small for decoded fields");
   end
   if ((STATUS_OFFSET % 4) != 0 || STATUS_IDX < NUM_CTRL) begin : g_bad_stat
      $error("phy_ctl_regbank: status offset misplaced");
   end
   if (STATUS_IDX >= (1 << IDX_W)) begin : g_stat_range
      $error("phy_ctl_regbank: status offset outside address space");
   end

   // address decode
   logic [IDX_W-1:0] word_idx;
   logic             aligned;
   logic             ctrl_hit;
   logic             status_hit;

   assign word_idx   = reg_addr[ADDR_W-1:2];
   assign aligned    = (reg_addr[1:0] == 2'b00);
   assign ctrl_hit   = aligned && (word_idx < NUM_CTRL_V);
   assign status_hit = aligned && (word_idx == STATUS_IDX_V);

   // control words
   logic [HALF_W-1:0] ctrl_q [NUM_CTRL];

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_ctrl
      logic sel;
      assign sel = reg_wr && ctrl_hit && (word_idx == IDX_W'(r));
      phy_hiword_reg #(.HALF_W(HALF_W)) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (sel),
         .wr_word (reg_wdata),
         .q       (ctrl_q[r])
      );
   end

   // status capture
   logic [STAT_W-1:0] stat_s;

   phy_status_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cal_done_i, dll_lock_i}),
      .q     (stat_s)
   );

   logic [WORD_W-1:0] status_word;
   always_comb begin
      status_word           = '0;
      status_word[CAL_BIT]  = stat_s[1];
      status_word[LOCK_BIT] = stat_s[0];
   end

   // read path
   logic [WORD_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (ctrl_hit) begin
         for (int r = 0; r < NUM_CTRL; r++) begin
            if (word_idx == IDX_W'(r)) rd_next = {{HALF_W{1'b0}}, ctrl_q[r]};
         end
      end else if (status_hit) begin
         rd_next = status_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rd_next;
   end

   // field decode
   assign ana_pwr_on   = ctrl_q[PWR_REG][PWR_BIT];
   assign dll_enable   = ctrl_q[PWR_REG][DLLEN_BIT];
   assign drv_strength = ctrl_q[PWR_REG][DRV_LSB +: DRV_W];
   assign dll_band     = ctrl_q[TAP_REG][BAND_LSB +: BAND_W];
   assign otap_enable  = ctrl_q[TAP_REG][TAPEN_BIT];
   assign otap_select  = ctrl_q[TAP_REG][TAPSEL_LSB +: TAPSEL_W];

   // R9
   unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !ctrl_hit && !status_hit) |=> (reg_rdata == '0));

   // R4
   ctrl_rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && ctrl_hit) |=> (reg_rdata[WORD_W-1:HALF_W] == '0));

   // R4
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R8
   status_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && status_hit) |=> ((reg_rdata & ~STATUS_MASK) == '0));

   // R10
   pwr_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && ctrl_hit && word_idx == PWR_IDX_V)
         |=> $stable({ana_pwr_on, dll_enable, drv_strength}));

   // R1
   reset_outputs_off_chk: assert property (@(posedge clk)
      !rst_n |-> (!ana_pwr_on && !dll_enable && reg_rdata == '0));

endmodule

// File: tb/tb_phy_ctl_regbank.sv
`timescale 1ns/1ps
module tb_phy_ctl_regbank;

   localparam int NCTRL = 7;
   localparam int SYNC  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic        cal = 1'b0;
   logic        lock = 1'b0;
   logic        pwr, dllen, otapen;
   logic [2:0]  drv;
   logic [1:0]  band;
   logic [3:0]  tapsel;

   always #2 clk = ~clk;

   phy_ctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
      .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata),
      .cal_done_i(cal), .dll_lock_i(lock),
      .ana_pwr_on(pwr), .dll_enable(dllen), .drv_strength(drv),
      .dll_band(band), .otap_enable(otapen), .otap_select(tapsel)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   bit live     = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_reg [NCTRL];
   logic [31:0] m_rdata;
   logic [1:0]  m_q [$];
   logic [31:0] m_rv;

   function automatic logic [31:0] model_read(logic [7:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      if (a < 8'h1C) return {16'h0, m_reg[a >> 2]};
      if (a == 8'h20) return (32'(m_q[0][1]) << 6) | (32'(m_q[0][0]) << 5);
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rdata = '0;
         for (int r = 0; r < NCTRL; r++) m_reg[r] = '0;
         m_q.delete();
         for (int s = 0; s < SYNC; s++) m_q.push_back(2'b00);
      end else begin
         m_rv = model_read(addr);
         if (rd) m_rdata = m_rv;
         if (wr && addr[1:0] == 2'b00 && addr < 8'h1C)
            m_reg[addr >> 2] = (m_reg[addr >> 2] & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
         m_q.push_back({cal, lock});
         void'(m_q.pop_front());
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (live && rst_n) begin
         chk("R4/R8/R9 model readback", rdata, m_rdata);
         chk("R6 power word fields", {27'h0, drv, dllen, pwr},
             {27'h0, m_reg[6][6:4], m_reg[6][1], m_reg[6][0]});
         chk("R7 tap word fields", {21'h0, band, otapen, tapsel},
             {21'h0, m_reg[0][13:12], m_reg[0][11], m_reg[0][10:7]});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      chk(tag, rdata, exp);
   endtask

   int unsigned seed = 32'h1234_5678;
   function automatic int unsigned next_rand();
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      return seed;
   endfunction

   logic [7:0] addr_pool [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                  8'h18, 8'h20, 8'h1C, 8'h24, 8'h02, 8'hFC};

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset outputs", {21'h0, band, otapen, tapsel, drv, dllen, pwr}, 32'h0);
      chk("R1 reset rdata", rdata, 32'h0);
      live = 1;
      bus_read(8'h18, 32'h0, "R1 power word after reset");

      // R6 decode of power word: power on, DLL on, drive code 1
      bus_write(8'h18, 32'h0073_0013);
      chk("R6 power on / dll / drive", {28'h0, drv, dllen, pwr}, {28'h0, 3'd1, 1'b1, 1'b1});
      // R3 empty mask changes nothing
      bus_write(8'h18, 32'h0000_FFFF);
      bus_read(8'h18, 32'h0000_0013, "R3 zero-mask write");
      // R2 partial mask clears only DLL enable
      bus_write(8'h18, 32'h0002_0000);
      bus_read(8'h18, 32'h0000_0011, "R2 partial mask");
      chk("R2 dll off, power stays", {30'h0, dllen, pwr}, 32'h1);
      // R7 band 2, tap enable, tap select 4
      bus_write(8'h00, 32'h3F80_2A00);
      chk("R7 tap fields", {24'h0, band, otapen, tapsel}, {24'h0, 2'd2, 1'b1, 4'd4});
      // R5 distinct words
      for (int r = 1; r < 6; r++) bus_write(8'(r * 4), 32'hFFFF_0000 | 32'(16'hA500 + r));
      for (int r = 1; r < 6; r++) bus_read(8'(r * 4), 32'(16'hA500 + r), "R5 independent word");
      bus_read(8'h00, 32'h0000_2A00, "R5 word 0 untouched");
      // R4 upper half reads as zero
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_read(8'h04, 32'h0000_FFFF, "R4 upper half zero");
      // R9 ignored writes and empty reads
      bus_write(8'h20, 32'hFFFF_FFFF);
      bus_write(8'h1C, 32'hFFFF_FFFF);
      bus_write(8'h1A, 32'hFFFF_FFFF);
      bus_read(8'h1C, 32'h0, "R9 unmapped read");
      bus_read(8'h02, 32'h0, "R9 misaligned read");
      bus_read(8'h18, 32'h0000_0011, "R9 misaligned write ignored");
      bus_read(8'h20, 32'h0, "R9 status write ignored");
      // R8 status synchronised
      @(negedge clk); cal = 1'b1;
      repeat (SYNC) @(negedge clk);
      bus_read(8'h20, 32'h0000_0040, "R8 calibration done");
      @(negedge clk); lock = 1'b1;
      repeat (SYNC) @(negedge clk);
      bus_read(8'h20, 32'h0000_0060, "R8 dll locked");
      // R10 outputs hold while other words are written
      bus_write(8'h08, 32'hFFFF_0000);
      chk("R10 power word stable", {30'h0, dllen, pwr}, 32'h1);

      // mixed random traffic against the model
      for (int i = 0; i < 600; i++) begin
         int unsigned r;
         r = next_rand();
         @(negedge clk);
         addr  = addr_pool[r % 12];
         wdata = next_rand();
         if (r[20]) wdata[31:16] = 16'h0;
         wr   = r[8];
         rd   = r[9];
         cal  = r[12] ^ cal;
         lock = r[13] ^ lock;
      end
      @(negedge clk); wr = 0; rd = 0;
      repeat (4) @(negedge clk);
      report();
   end

endmodule